// File: doc/BRIEF.md
# Concatenated-Increment Carry Skip Adder

This block is a purely combinational N-bit adder that returns A + B + Cin as an N-bit sum and a carry-out. The operand bits are divided into stages whose widths are set at elaboration. Only the lowest stage is a plain ripple chain driven by the external carry-in. Each higher stage first adds its own operand slice with a zero carry-in, so all stages form their intermediate sums at the same time. It then adds the carry arriving from the stage below through a chain of half adders.

Stage carries travel through one compound skip gate per stage. A stage's carry is 1 when its own zero-carry-in ripple block produces a carry. It passes the incoming carry when every intermediate sum bit of the stage is 1. Otherwise it is 0. The skip gates alternate between an AND-OR-invert form and an OR-AND-invert form. As a result the carry on the skip path is true polarity after odd-numbered stages and inverted after even-numbered ones. The top module restores true polarity at the carry-out whatever the stage count. The default build is 32 bits in ten stages of widths 1,2,3,4,5,6,5,3,2,1. Elaboration stops if the widths do not sum to N.

Top module: `csk_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals the (N+1)-bit value a + b + cin.
- R2: When every bit of a XOR b is 1, sum is all ones and cout is 0 for cin = 0, and sum is all zeros and cout is 1 for cin = 1.
- R3: When a and b are both all ones, cout is 1, sum bit 0 equals cin, and every other sum bit is 1.
- R4: When a and b are both zero, sum equals cin (zero-extended) and cout is 0.
- R5: The true-polarity carry leaving each stage equals the carry out of adding the operand bits below that stage's upper boundary together with cin.
- R6: For every stage above the first, the stage carry is 1 when that stage's zero-carry-in ripple block carries. If that block does not carry, the stage carry equals the incoming carry when all the stage's intermediate sum bits are 1, and is 0 otherwise.
- R7: In every stage above the first, the final sum bits are the intermediate sum plus the incoming carry, with the incrementer's own overflow discarded. A stage whose operand slice sums to all ones and that receives a carry outputs all-zero sum bits and forwards the carry.
- R8: sum and cout are true polarity whether the number of stages is even or odd.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| cin | input | 1 | Carry into the lowest stage |
| sum | output | N | Low N bits of a + b + cin |
| cout | output | 1 | Carry out of the top stage, true polarity |

## Verification
On every input change the assertions check the full sum against arithmetic. They check every internal stage boundary carry against the carry of the matching low-order slice, and they check each skip gate's decision from its ripple carry and all-ones signal. They also check the fixed results for all-propagate, all-generate and zero operands. What the assertions cannot show is that those decisions are right when the polarity alternates through an odd stage count, or that a carry rippling across whole stages clears each incremented slice. The bench's second instance, with an odd number of stages, and its directed boundary patterns, which set a carry just below each stage and make the stage's slice all ones, show these.

// File: rtl/csk_pkg.sv
// Package: shared types for the carry skip adder.
// Assumes nothing beyond the standard data types.
package csk_pkg;
    // Which compound gate a skip stage uses.
    typedef enum logic {
        SKIP_AOI = 1'b0,  // true-polarity carry in, inverted carry out
        SKIP_OAI = 1'b1   // inverted carry in, true-polarity carry out
    } skip_kind_e;
endpackage

// File: rtl/csk_ripple_cin.sv
// Ripple block with an external carry-in: a chain of W full adders.
// Assumes W >= 1. Used only for the lowest stage.
module csk_ripple_cin #(
    parameter int unsigned W = 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        // One full adder cell.
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[W];
endmodule

// File: rtl/csk_ripple_zc.sv
// Ripple block with its carry-in tied to zero: a half adder in the lowest
// cell, full adders above it. Produces the intermediate sum of a stage
// without waiting for any lower stage. Assumes W >= 1.
module csk_ripple_zc #(
    parameter int unsigned W = 1
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] z,
    output logic         co
);
    logic [W:0] c;

    // Lowest cell is a half adder since the carry-in is zero.
    assign z[0] = a[0] ^ b[0];
    assign c[1] = a[0] & b[0];

    for (genvar i = 1; i < W; i++) begin : g_fa
        // Full adder cells above the half adder.
        assign z[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign c[0] = 1'b0;
    assign co   = c[W] | c[0];
endmodule

// File: rtl/csk_incr.sv
// Incrementer: a half-adder chain that adds a single carry to an
// intermediate sum. The overflow of the top cell is never formed, because
// the stage carry comes from the skip gate instead. Assumes W >= 1.
module csk_incr #(
    parameter int unsigned W = 1
) (
    input  logic [W-1:0] z,
    input  logic         ci,
    output logic [W-1:0] s
);
    logic [W-1:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_ha
        // Half adder sum output.
        assign s[i] = z[i] ^ c[i];
        if (i + 1 < W) begin : g_cy
            // Half adder carry, forwarded only inside the chain.
            assign c[i+1] = z[i] & c[i];
        end
    end
endmodule

// File: rtl/csk_skip_cell.sv
// Inverting compound skip gate. The AOI form takes a true carry and
// returns it inverted. The OAI form takes an inverted carry and returns it
// true. gen and prop are always true polarity; the OAI form inverts them
// locally, off the skip path.
module csk_skip_cell
    import csk_pkg::*;
#(
    parameter skip_kind_e KIND = SKIP_AOI
) (
    input  logic gen,    // stage ripple block carried
    input  logic prop,   // all intermediate sum bits are 1
    input  logic cx,     // carry from previous stage, polarity per KIND
    output logic cy      // carry to next stage, opposite polarity
);
    if (KIND == SKIP_AOI) begin : g_aoi
        // AND-OR-invert: cy = not(gen or (prop and cx)).
        assign cy = ~(gen | (prop & cx));
    end else begin : g_oai
        // OR-AND-invert on locally inverted gen/prop with inverted cx.
        assign cy = ~(~gen & (~prop | cx));
    end
endmodule

// File: rtl/csk_adder.sv
// Top: concatenated-increment carry skip adder, fully combinational.
// Stage k (0-based) covers STG_W[k] bits above the stages below it.
// Stage 0 is a ripple chain fed by cin. Higher stages add with zero carry-in,
// then increment by the incoming carry. Stage carries travel on an
// alternating-polarity skip chain: true after even k, inverted after odd k.
// Assumes NUM_STG >= 2, every width >= 1, and widths summing to N.
module csk_adder
    import csk_pkg::*;
#(
    parameter int unsigned N                = 32,
    parameter int unsigned NUM_STG          = 10,
    parameter int unsigned STG_W [NUM_STG]  = '{1, 2, 3, 4, 5, 6, 5, 3, 2, 1}
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N-1:0] sum,
    output logic         cout
);
    // Lowest bit index of stage k.
    function automatic int unsigned base_of(input int unsigned k);
        int unsigned acc = 0;
        for (int unsigned i = 0; i < k; i++) acc += STG_W[i];
        return acc;
    endfunction

    localparam int unsigned TOTAL_W = base_of(NUM_STG);
    localparam bit          TOP_INV = ((NUM_STG - 1) % 2) == 1;

    if (TOTAL_W != N) begin : g_bad_sizes
        $error("csk_adder: stage widths sum to %0d, expected %0d", TOTAL_W, N);
    end

    logic [NUM_STG-1:0] skip_chain;  // per-stage carry, alternating polarity
    logic [NUM_STG-1:1] blk_gen;     // zero-carry-in ripple block carried
    logic [NUM_STG-1:1] blk_allp;    // intermediate sum bits all ones

    for (genvar k = 0; k < NUM_STG; k++) begin : g_stg
        localparam int unsigned W  = STG_W[k];
        localparam int unsigned LO = base_of(k);

        if (k == 0) begin : g_first
            // Lowest stage: plain ripple chain, true-polarity carry out.
            csk_ripple_cin #(.W(W)) u_rca (
                .a   (a[LO +: W]),
                .b   (b[LO +: W]),
                .cin (cin),
                .s   (sum[LO +: W]),
                .co  (skip_chain[0])
            );
        end else begin : g_upper
            logic [W-1:0] z;
            logic         rc;
            logic         prev_t;

            // Intermediate sum formed with zero carry-in.
            csk_ripple_zc #(.W(W)) u_rca (
                .a  (a[LO +: W]),
                .b  (b[LO +: W]),
                .z  (z),
                .co (rc)
            );

            // Incoming carry in true polarity for the incrementer.
            if ((k % 2) == 1) begin : g_prev_true
                assign prev_t = skip_chain[k-1];
            end else begin : g_prev_inv
                assign prev_t = ~skip_chain[k-1];
            end

            // Final stage sum bits.
            csk_incr #(.W(W)) u_inc (
                .z  (z),
                .ci (prev_t),
                .s  (sum[LO +: W])
            );

            assign blk_gen[k]  = rc;
            assign blk_allp[k] = &z;

            // Skip gate: AOI on odd stages, OAI on even stages.
            csk_skip_cell #(
                .KIND(((k % 2) == 1) ? SKIP_AOI : SKIP_OAI)
            ) u_skip (
                .gen  (rc),
                .prop (blk_allp[k]),
                .cx   (skip_chain[k-1]),
                .cy   (skip_chain[k])
            );
        end
    end

    // Restore true polarity at the final carry-out.
    if (TOP_INV) begin : g_cout_inv
        assign cout = ~skip_chain[NUM_STG-1];
    end else begin : g_cout_true
        assign cout = skip_chain[NUM_STG-1];
    end
endmodule

// File: rtl/csk_adder_chk.sv
// Checker for csk_adder, bound to every instance. The adder has no clock,
// so the checks are immediate assertions evaluated whenever inputs settle.
module csk_adder_chk #(
    parameter int unsigned N                = 32,
    parameter int unsigned NUM_STG          = 10,
    parameter int unsigned STG_W [NUM_STG]  = '{1, 2, 3, 4, 5, 6, 5, 3, 2, 1}
) (
    input logic [N-1:0]         a,
    input logic [N-1:0]         b,
    input logic                 cin,
    input logic [N-1:0]         sum,
    input logic                 cout,
    input logic [NUM_STG-1:0]   skip_chain,
    input logic [NUM_STG-1:1]   blk_gen,
    input logic [NUM_STG-1:1]   blk_allp
);
    // Arithmetic, corner-case and per-stage carry checks.
    always_comb begin
        logic [N:0]   ref_full;
        logic [N:0]   mask;
        logic [N:0]   part;
        logic [NUM_STG-1:0] tcar;
        int unsigned  bnd;

        ref_full = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, cin};
        assert_full_sum_R1: assert ({cout, sum} == ref_full)
            else $error("R1 sum mismatch");

        if (&(a ^ b)) begin
            assert_all_prop_R2: assert ((cout == cin) && (sum == {N{~cin}}))
                else $error("R2 all-propagate result wrong");
        end
        if ((&a) && (&b)) begin
            assert_all_gen_R3: assert (cout && (sum == {{(N-1){1'b1}}, cin}))
                else $error("R3 all-generate result wrong");
        end
        if ((a == '0) && (b == '0)) begin
            assert_zero_ops_R4: assert (!cout && (sum == {{(N-1){1'b0}}, cin}))
                else $error("R4 zero-operand result wrong");
        end

        bnd = 0;
        for (int k = 0; k < NUM_STG; k++) begin
            tcar[k] = ((k % 2) == 0) ? skip_chain[k] : ~skip_chain[k];
            bnd += STG_W[k];
            mask = '0;
            for (int i = 0; i < N; i++) mask[i] = (i < bnd);
            part = ({1'b0, a} & mask) + ({1'b0, b} & mask) + {{N{1'b0}}, cin};
            assert_stage_carry_R5: assert (tcar[k] == part[bnd])
                else $error("R5 stage %0d carry wrong", k);
            if (k > 0) begin
                assert_skip_rule_R6: assert (tcar[k] ==
                        (blk_gen[k] ? 1'b1 : (blk_allp[k] ? tcar[k-1] : 1'b0)))
                    else $error("R6 skip decision wrong at stage %0d", k);
            end
        end
    end
endmodule

bind csk_adder csk_adder_chk #(
    .N       (N),
    .NUM_STG (NUM_STG),
    .STG_W   (STG_W)
) u_chk (
    .a          (a),
    .b          (b),
    .cin        (cin),
    .sum        (sum),
    .cout       (cout),
    .skip_chain (skip_chain),
    .blk_gen    (blk_gen),
    .blk_allp   (blk_allp)
);

// File: tb/sim_csk_adder.sv
// Bench for csk_adder: drives vectors at the rising edge and compares both
// instances against a behavioural reference at the falling edge.
// u0 is the default 32-bit, ten-stage build; u1 is an 8-bit five-stage build
// so that the odd stage count is covered.
module sim_csk_adder;
    localparam int unsigned N        = 32;
    localparam int unsigned NS       = 10;
    localparam int unsigned SW [NS]  = '{1, 2, 3, 4, 5, 6, 5, 3, 2, 1};
    localparam int unsigned N1       = 8;
    localparam int unsigned NS1      = 5;
    localparam int unsigned SW1 [NS1] = '{1, 2, 2, 2, 1};
    localparam time         CLK_HALF = 2ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] ta = '0;
    logic [N-1:0] tb = '0;
    logic         tcin = 1'b0;
    logic [N-1:0] sum0;
    logic         cout0;
    logic [N1-1:0] sum1;
    logic          cout1;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    csk_adder #(.N(N), .NUM_STG(NS), .STG_W(SW)) u0 (
        .a(ta), .b(tb), .cin(tcin), .sum(sum0), .cout(cout0)
    );

    csk_adder #(.N(N1), .NUM_STG(NS1), .STG_W(SW1)) u1 (
        .a(ta[N1-1:0]), .b(tb[N1-1:0]), .cin(tcin), .sum(sum1), .cout(cout1)
    );

    // Compare both instances against the reference for the current inputs.
    task automatic check(input string req);
        logic [N:0]  exp0;
        logic [N1:0] exp1;
        exp0 = {1'b0, ta} + {1'b0, tb} + {{N{1'b0}}, tcin};
        exp1 = {1'b0, ta[N1-1:0]} + {1'b0, tb[N1-1:0]} + {{N1{1'b0}}, tcin};
        n_chk++;
        if ({cout0, sum0} !== exp0) begin
            n_err++;
            $display("FAIL %s u0 a=%h b=%h cin=%b got %h expected %h",
                     req, ta, tb, tcin, {cout0, sum0}, exp0);
        end
        n_chk++;
        if ({cout1, sum1} !== exp1) begin
            n_err++;
            $display("FAIL %s R8 u1 a=%h b=%h cin=%b got %h expected %h",
                     req, ta[N1-1:0], tb[N1-1:0], tcin, {cout1, sum1}, exp1);
        end
    endtask

    // Drive one vector at the rising edge, check at the falling edge.
    task automatic apply(input logic [N-1:0] va, input logic [N-1:0] vb,
                         input logic vc, input string req);
        @(posedge clk);
        ta   <= va;
        tb   <= vb;
        tcin <= vc;
        @(negedge clk);
        check(req);
    endtask

    // Main stimulus sequence.
    initial begin
        logic [N-1:0] pa;
        logic [N-1:0] pb;
        int unsigned  lo;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R4 reset state");
        rst_n = 1'b1;

        // R2: all-propagate, both carry-in values, two bit patterns.
        apply({(N/2){2'b10}}, {(N/2){2'b01}}, 1'b0, "R2 all-propagate cin0");
        apply({(N/2){2'b10}}, {(N/2){2'b01}}, 1'b1, "R2 all-propagate cin1");
        apply('1, '0, 1'b1, "R2 all-propagate ones cin1");
        apply('0, '1, 1'b0, "R2 all-propagate ones cin0");
        // R3: all-generate.
        apply('1, '1, 1'b0, "R3 all-generate cin0");
        apply('1, '1, 1'b1, "R3 all-generate cin1");
        // R4: zero operands.
        apply('0, '0, 1'b0, "R4 zero cin0");
        apply('0, '0, 1'b1, "R4 zero cin1");

        // R5 and R7: carry generated just below each stage, slice all ones.
        lo = 0;
        for (int k = 0; k < NS; k++) begin
            if (k > 0) begin
                pa = '0;
                pb = '0;
                pa[lo-1] = 1'b1;
                pb[lo-1] = 1'b1;
                for (int i = 0; i < SW[k]; i++) pa[lo+i] = 1'b1;
                apply(pa, pb, 1'b0, "R7 incremented slice wraps");
                pa = pa | ~((N'(1) << lo) - 1);
                apply(pa, pb, 1'b0, "R5 carry skips upper stages");
            end
            lo += SW[k];
        end

        // R6: block carry alone, no incoming carry, per stage.
        lo = 0;
        for (int k = 0; k < NS; k++) begin
            pa = '0;
            pb = '0;
            pa[lo + SW[k] - 1] = 1'b1;
            pb[lo + SW[k] - 1] = 1'b1;
            apply(pa, pb, 1'b0, "R6 block generate");
            lo += SW[k];
        end

        // R1 and R8: random operands on both instances.
        for (int n = 0; n < 3000; n++) begin
            apply(N'({$urandom, $urandom}), N'({$urandom, $urandom}),
                  1'($urandom), "R1 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_HALF * 2 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule